// File: doc/BRIEF.md
# Set/Clear Control Register Bank

This block is a slice of register storage for one peripheral on a simple peripheral bus. Each control register that software changes often is reached at three word addresses. One address ORs the written ones into the register. A second address clears the bits where a one is written. A third address reads the stored value. Software can therefore flip a single bit with one write and needs no read-modify-write sequence.

The block claims a 16 KB window. By default the window sits in the top megabyte of the 32-bit address space, and its base is the lowest address of the window. Inside the window the block holds these registers:

- a control register with set, clear and read access;
- plain read/write mode and data registers;
- a sticky status register, set by event inputs from the peripheral and cleared by software with write-one;
- an interrupt mask register with set, clear and read access.

The interrupt output combines the status and mask registers. Bus writes take effect on the rising clock edge while select and write are high. Read data is combinational while select is high and write is low.

Top module: `sc_regbank`

## Requirements
- R1: After reset, every register (control, mode, data, status, mask) holds zero and `irq_o` is low.
- R2: A write to byte offset 0x00 sets every control-register bit for which the write data bit is one.
- R3: A write to byte offset 0x04 clears every control-register bit for which the write data bit is one.
- R4: A zero bit in the data of a write to offset 0x00 or 0x04 leaves that control bit unchanged. No other access changes the control register.
- R5: A read of offset 0x08 returns the control register. Reads of 0x00 and 0x04 return zero. Writes to 0x08 are ignored.
- R6: Offsets 0x10 (mode) and 0x14 (data) are plain registers: a write stores the full word, and a read returns it.
- R7: A status bit becomes one at a clock edge where the matching `evt_i` bit is high, and then stays one. A write of ones to offset 0x24 clears those status bits. If an event and a clear hit the same bit in the same cycle, the event wins. Offset 0x20 reads the status register, and writes to 0x20 are ignored.
- R8: The mask register is set at offset 0x30, cleared at offset 0x34 (ones act, zeros do nothing) and read at offset 0x38.
- R9: `irq_o` is high exactly when some bit is one in both the status register and the mask register.
- R10: An access is in the window when `bus_addr[31:14]` equals `BASE[31:14]` (default base 0xFFFE0000). `bus_addr[1:0]` are ignored. Accesses outside the window, and accesses to offsets not listed above, change nothing and read as zero. `bus_rdata` is zero whenever there is no read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Byte address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, zero when no read |
| evt_i | input | DW | Peripheral event bits, one per status bit |
| irq_o | output | 1 | Interrupt request |

## Verification
On every cycle, the assertions check these rules: the control register changes only through its set and clear addresses, with OR and AND-NOT semantics; status bits never fall unless a clear write is made; out-of-window accesses leave the registers untouched; idle read data is zero; and the interrupt never rises without a mask bit and a status bit. Only the bench scenarios show the following:

- the exact readback values at each address;
- that the set and clear aliases read as zero;
- that writes to read-only addresses are ignored;
- the priority of an event over a same-cycle clear;
- that the interrupt follows the exact status and mask overlap.

// File: rtl/sc_regbank_pkg.sv
package sc_regbank_pkg;

    // word offsets inside the window (byte address bits [13:2])
    localparam int OFFW = 12;
    localparam logic [OFFW-1:0] OFF_CTRL_SET = 12'h000;
    localparam logic [OFFW-1:0] OFF_CTRL_CLR = 12'h001;
    localparam logic [OFFW-1:0] OFF_CTRL_RD  = 12'h002;
    localparam logic [OFFW-1:0] OFF_MODE     = 12'h004;
    localparam logic [OFFW-1:0] OFF_DATA     = 12'h005;
    localparam logic [OFFW-1:0] OFF_STAT_RD  = 12'h008;
    localparam logic [OFFW-1:0] OFF_STAT_CLR = 12'h009;
    localparam logic [OFFW-1:0] OFF_MASK_SET = 12'h00C;
    localparam logic [OFFW-1:0] OFF_MASK_CLR = 12'h00D;
    localparam logic [OFFW-1:0] OFF_MASK_RD  = 12'h00E;

    typedef enum logic [3:0] {
        ID_NONE,
        ID_CTRL_SET,
        ID_CTRL_CLR,
        ID_CTRL_RD,
        ID_MODE,
        ID_DATA,
        ID_STAT_RD,
        ID_STAT_CLR,
        ID_MASK_SET,
        ID_MASK_CLR,
        ID_MASK_RD
    } reg_id_e;

endpackage

// File: rtl/sc_addr_dec.sv
module sc_addr_dec
    import sc_regbank_pkg::*;
#(
    parameter logic [31:0] BASE = 32'hFFFE_0000
) (
    input  logic [31:2] addr_w,
    output logic        in_win,
    output reg_id_e     reg_id
);
    localparam int TAGW = 32 - 14;
    localparam logic [TAGW-1:0] WIN_TAG = BASE[31:14];

    logic [OFFW-1:0] off;

    always_comb begin
        off    = addr_w[13:2];
        in_win = (addr_w[31:14] == WIN_TAG);
        reg_id = ID_NONE;
        if (in_win) begin
            unique case (off)
                OFF_CTRL_SET: reg_id = ID_CTRL_SET;
                OFF_CTRL_CLR: reg_id = ID_CTRL_CLR;
                OFF_CTRL_RD:  reg_id = ID_CTRL_RD;
                OFF_MODE:     reg_id = ID_MODE;
                OFF_DATA:     reg_id = ID_DATA;
                OFF_STAT_RD:  reg_id = ID_STAT_RD;
                OFF_STAT_CLR: reg_id = ID_STAT_CLR;
                OFF_MASK_SET: reg_id = ID_MASK_SET;
                OFF_MASK_CLR: reg_id = ID_MASK_CLR;
                OFF_MASK_RD:  reg_id = ID_MASK_RD;
                default:      reg_id = ID_NONE;
            endcase
        end
    end
endmodule

// File: rtl/sc_bitreg.sv
module sc_bitreg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_en,
    input  logic         clr_en,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] hw_set,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] bits;
    } bit_st_t;

    bit_st_t st_d, st_q;

    // clear first, then software set, then hardware set: setting wins
    always_comb begin
        st_d = st_q;
        if (clr_en) st_d.bits = st_d.bits & ~wdata;
        if (set_en) st_d.bits = st_d.bits | wdata;
        st_d.bits = st_d.bits | hw_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q = st_q.bits;
endmodule

// File: rtl/sc_regbank.sv
module sc_regbank
    import sc_regbank_pkg::*;
#(
    parameter int          DW   = 32,
    parameter logic [31:0] BASE = 32'hFFFE_0000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [31:0]   bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic [DW-1:0] evt_i,
    output logic          irq_o
);
    typedef struct packed {
        logic [DW-1:0] mode;
        logic [DW-1:0] data;
    } plain_t;

    plain_t  pl_d, pl_q;
    reg_id_e reg_id;
    logic    in_win;
    logic    wr_en;
    logic    addr_lsb_unused;

    logic [DW-1:0] ctrl_q, stat_q, mask_q, mode_q, data_q;
    logic [DW-1:0] zero_vec;

    assign zero_vec        = '0;
    assign addr_lsb_unused = ^bus_addr[1:0];
    assign wr_en           = bus_sel & bus_wr;

    sc_addr_dec #(.BASE(BASE)) u_dec (
        .addr_w (bus_addr[31:2]),
        .in_win (in_win),
        .reg_id (reg_id)
    );

    sc_bitreg #(.W(DW)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_en (wr_en && reg_id == ID_CTRL_SET),
        .clr_en (wr_en && reg_id == ID_CTRL_CLR),
        .wdata  (bus_wdata),
        .hw_set (zero_vec),
        .q      (ctrl_q)
    );

    sc_bitreg #(.W(DW)) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_en (wr_en && reg_id == ID_MASK_SET),
        .clr_en (wr_en && reg_id == ID_MASK_CLR),
        .wdata  (bus_wdata),
        .hw_set (zero_vec),
        .q      (mask_q)
    );

    sc_bitreg #(.W(DW)) u_stat (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_en (1'b0),
        .clr_en (wr_en && reg_id == ID_STAT_CLR),
        .wdata  (bus_wdata),
        .hw_set (evt_i),
        .q      (stat_q)
    );

    always_comb begin
        pl_d = pl_q;
        if (wr_en && reg_id == ID_MODE) pl_d.mode = bus_wdata;
        if (wr_en && reg_id == ID_DATA) pl_d.data = bus_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pl_q <= '0;
        else        pl_q <= pl_d;
    end

    assign mode_q = pl_q.mode;
    assign data_q = pl_q.data;

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            unique case (reg_id)
                ID_CTRL_RD: bus_rdata = ctrl_q;
                ID_MODE:    bus_rdata = mode_q;
                ID_DATA:    bus_rdata = data_q;
                ID_STAT_RD: bus_rdata = stat_q;
                ID_MASK_RD: bus_rdata = mask_q;
                default:    bus_rdata = '0;
            endcase
        end
    end

    assign irq_o = |(stat_q & mask_q);
endmodule

// File: rtl/sc_regbank_chk.sv
module sc_regbank_chk
    import sc_regbank_pkg::*;
#(
    parameter int          DW   = 32,
    parameter logic [31:0] BASE = 32'hFFFE_0000
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_sel,
    input logic          bus_wr,
    input logic [31:0]   bus_addr,
    input logic [DW-1:0] bus_wdata,
    input logic [DW-1:0] bus_rdata,
    input logic          irq_o,
    input logic [DW-1:0] ctrl_q,
    input logic [DW-1:0] stat_q,
    input logic [DW-1:0] mask_q,
    input logic [DW-1:0] mode_q,
    input logic [DW-1:0] data_q
);
    logic            win;
    logic [OFFW-1:0] off;
    logic            w_set, w_clr, w_sclr;

    assign win    = (bus_addr[31:14] == BASE[31:14]);
    assign off    = bus_addr[13:2];
    assign w_set  = bus_sel && bus_wr && win && off == OFF_CTRL_SET;
    assign w_clr  = bus_sel && bus_wr && win && off == OFF_CTRL_CLR;
    assign w_sclr = bus_sel && bus_wr && win && off == OFF_STAT_CLR;

    AST_CTRL_SET_OR: assert property (@(posedge clk) disable iff (!rst_n)
        w_set |=> ctrl_q == ($past(ctrl_q) | $past(bus_wdata))); // R2

    AST_CTRL_CLR_ANDN: assert property (@(posedge clk) disable iff (!rst_n)
        w_clr |=> ctrl_q == ($past(ctrl_q) & ~$past(bus_wdata))); // R3

    AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(w_set || w_clr) |=> $stable(ctrl_q)); // R4

    AST_STAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !w_sclr |=> ((stat_q & $past(stat_q)) == $past(stat_q))); // R7

    AST_IRQ_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (mask_q != '0) && (stat_q != '0)); // R9

    AST_OUT_WIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !win) |=> $stable(mode_q) && $stable(data_q) && $stable(mask_q)); // R10

    AST_IDLE_RDATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_sel |-> bus_rdata == '0); // R10
endmodule

bind sc_regbank sc_regbank_chk #(.DW(DW), .BASE(BASE)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_o     (irq_o),
    .ctrl_q    (ctrl_q),
    .stat_q    (stat_q),
    .mask_q    (mask_q),
    .mode_q    (mode_q),
    .data_q    (data_q)
);

// File: tb/sim_sc_regbank.sv
`timescale 1ns/1ps
module sim_sc_regbank;
    localparam int          DW = 32;
    localparam logic [31:0] B  = 32'hFFFE_0000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0;
    logic          bus_wr = 1'b0;
    logic [31:0]   bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic [DW-1:0] evt_i = '0;
    logic          irq_o;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    sc_regbank #(.DW(DW), .BASE(B)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .evt_i(evt_i), .irq_o(irq_o)
    );

    // {req, wr, addr, data}; for reads data is the expected value
    localparam int NV = 23;
    localparam logic [72:0] VEC [NV] = '{
        {8'd2,  1'b1, B + 32'h00, 32'h0000_00F0},
        {8'd2,  1'b0, B + 32'h08, 32'h0000_00F0}, // R2
        {8'd4,  1'b1, B + 32'h00, 32'h0000_0003},
        {8'd4,  1'b0, B + 32'h08, 32'h0000_00F3}, // R4
        {8'd3,  1'b1, B + 32'h04, 32'h0000_0030},
        {8'd3,  1'b0, B + 32'h08, 32'h0000_00C3}, // R3
        {8'd4,  1'b1, B + 32'h04, 32'h0000_0000},
        {8'd4,  1'b0, B + 32'h08, 32'h0000_00C3}, // R4
        {8'd5,  1'b0, B + 32'h00, 32'h0000_0000}, // R5
        {8'd5,  1'b0, B + 32'h04, 32'h0000_0000}, // R5
        {8'd5,  1'b1, B + 32'h08, 32'hFFFF_FFFF},
        {8'd5,  1'b0, B + 32'h08, 32'h0000_00C3}, // R5
        {8'd6,  1'b1, B + 32'h10, 32'hA5A5_1234},
        {8'd6,  1'b1, B + 32'h14, 32'h0BAD_F00D},
        {8'd6,  1'b0, B + 32'h10, 32'hA5A5_1234}, // R6
        {8'd6,  1'b0, B + 32'h14, 32'h0BAD_F00D}, // R6
        {8'd8,  1'b1, B + 32'h30, 32'h0000_000F},
        {8'd8,  1'b1, B + 32'h34, 32'h0000_0005},
        {8'd8,  1'b0, B + 32'h38, 32'h0000_000A}, // R8
        {8'd10, 1'b1, B + 32'h100, 32'hDEAD_BEEF},
        {8'd10, 1'b1, 32'h1FFE_0000, 32'hFFFF_FFFF},
        {8'd10, 1'b0, B + 32'h0B, 32'h0000_00C3}, // R10 byte bits ignored
        {8'd10, 1'b0, 32'h1FFE_0008, 32'h0000_0000} // R10 outside window
    };

    task automatic check(input bit ok, input string req,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [31:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [31:0] a, output logic [DW-1:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic read_check(input logic [31:0] a, input logic [DW-1:0] exp,
                              input string req);
        logic [DW-1:0] got;
        bus_read(a, got);
        check(got === exp, req, got, exp);
    endtask

    task automatic pulse_evt(input logic [DW-1:0] e, input bit with_clr,
                             input logic [DW-1:0] clr);
        @(negedge clk);
        evt_i = e;
        if (with_clr) begin
            bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = B + 32'h24; bus_wdata = clr;
        end
        @(negedge clk);
        evt_i = '0; bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    endtask

    initial begin
        logic [DW-1:0] got;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(irq_o === 1'b0, "R1", {31'd0, irq_o}, '0);
        check(bus_rdata === '0, "R10", bus_rdata, '0);
        rst_n = 1'b1;
        read_check(B + 32'h08, '0, "R1");
        read_check(B + 32'h10, '0, "R1");
        read_check(B + 32'h20, '0, "R1");
        read_check(B + 32'h38, '0, "R1");

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][64]) begin
                bus_write(VEC[i][63:32], VEC[i][31:0]);
            end else begin
                bus_read(VEC[i][63:32], got);
                check(got === VEC[i][31:0], $sformatf("R%0d", VEC[i][72:65]),
                      got, VEC[i][31:0]);
            end
        end
        // R10: undefined-offset write and out-of-window write had no effect
        read_check(B + 32'h100, '0, "R10");
        read_check(B + 32'h38, 32'h0000_000A, "R10");
        read_check(B + 32'h10, 32'hA5A5_1234, "R10");

        // R7 / R9: status and interrupt, mask = 0xA
        pulse_evt(32'h2, 1'b0, '0);
        read_check(B + 32'h20, 32'h2, "R7");
        #1 check(irq_o === 1'b1, "R9", {31'd0, irq_o}, 32'd1);
        pulse_evt(32'h1, 1'b0, '0);
        read_check(B + 32'h20, 32'h3, "R7");
        bus_write(B + 32'h24, 32'h2);
        read_check(B + 32'h20, 32'h1, "R7");
        #1 check(irq_o === 1'b0, "R9", {31'd0, irq_o}, 32'd0);
        pulse_evt(32'h1, 1'b1, 32'h1); // R7 event beats same-cycle clear
        read_check(B + 32'h20, 32'h1, "R7");
        bus_write(B + 32'h20, 32'hFFFF_FFFF); // R7 write to read address ignored
        read_check(B + 32'h20, 32'h1, "R7");
        bus_write(B + 32'h30, 32'h1);
        #1 check(irq_o === 1'b1, "R9", {31'd0, irq_o}, 32'd1);

        // R1 mid-run reset
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check(irq_o === 1'b0, "R1", {31'd0, irq_o}, '0);
        rst_n = 1'b1;
        read_check(B + 32'h08, '0, "R1");
        read_check(B + 32'h14, '0, "R1");
        read_check(B + 32'h20, '0, "R1");
        read_check(B + 32'h38, '0, "R1");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule